// File: doc/BRIEF.md
# Interrupt Status and Enable Aggregator

This block is the central interrupt collector of a network controller. Event sources raise bits in a status register, and an enable register selects which of those bits count. A single pending level forms when any enabled status bit is set. A configuration register carries a master gate for the interrupt pin. It also carries a read-only pending flag that shows the pending level even while the pin is gated off.

Software reaches three registers through a simple word-wide read and write port. Status bits are cleared by writing ones to them. The enable register is written as a whole. A write to the configuration register touches only the master gate.

Two bit positions behave in a special way. A timer-expiry input sets its status bit only while the matching enable bit is set. A PHY interrupt level input is copied straight into its status bit. Every other status bit is set by a one-cycle pulse on the generic event vector.

Top module: `irq_aggr`

## Requirements
- R1: After reset the status register, the enable register and the master gate are all 0, irq_o is 0, and every register reads as 0. Address 0 is status, address 1 is enable, address 2 is configuration, and address 3 reads as 0.
- R2: A write to address 0 clears each status bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged. The change is visible from the next clock edge.
- R3: When a generic event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: A timer-expiry pulse sets status bit TMR_BIT (default 19) only if enable bit TMR_BIT is set in that cycle. Otherwise the pulse is lost.
- R5: Status bit PHY_BIT (default 26) follows phy_lvl_i one cycle later. A write-one-to-clear cannot hold that bit low while phy_lvl_i is high.
- R6: Configuration read bit 12 equals the pending level, meaning the AND of status and enable is nonzero. This holds whatever the state of the master gate.
- R7: irq_o is active-high. It is 1 exactly when the pending level is 1 and master-gate bit 8 is 1.
- R8: A write to address 2 updates only bit 8. Bit 12 stays as computed, and all other configuration bits, including the reserved bits 4 and 0, read as 0.
- R9: A write to address 1 replaces the whole enable register, and the new value reads back from the next edge.
- R10: Generic event pulses on positions TMR_BIT and PHY_BIT have no effect. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; rdata_o is 0 when low |
| addr_i | input | 2 | Register select |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from addr_i |
| evt_set_i | input | DW | One-cycle set pulses, one per status bit |
| tmr_evt_i | input | 1 | Timer-expiry pulse |
| phy_lvl_i | input | 1 | PHY masked interrupt level |
| irq_o | output | 1 | Interrupt pin, active-high |

## Verification
The assertions assume that every input is known and that each input changes only between clock edges. The bench meets this by driving all inputs on the falling edge and returning the pulse inputs to zero within the same cycle. The assertions also treat generic pulses on the timer and PHY positions as meaningless, and the random stimulus deliberately sets those positions to confirm that they are ignored. Because the set-versus-clear property assumes a clear and a set may coincide, the random mix overlaps status writes with event pulses often.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_CFG  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int DW      = 32,
  parameter int TMR_BIT = 19,
  parameter int PHY_BIT = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] set_i,
  input  logic          tmr_evt_i,
  input  logic          tmr_en_i,
  input  logic          phy_lvl_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] stat_q, stat_d;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == PHY_BIT) begin : g_phy
      // level-driven source: tracks the input
      assign stat_d[b] = phy_lvl_i;
    end else if (b == TMR_BIT) begin : g_tmr
      assign stat_d[b] = (stat_q[b] & ~clr_i[b]) | (tmr_evt_i & tmr_en_i);
    end else begin : g_gen
      // set has priority over clear
      assign stat_d[b] = (stat_q[b] & ~clr_i[b]) | set_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int DW      = 32,
  parameter int MEN_BIT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_we_i,
  input  logic          cfg_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] en_o,
  output logic          men_o
);
  logic [DW-1:0] en_q;
  logic          men_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      men_q <= 1'b0;
    end else begin
      if (en_we_i)  en_q  <= wdata_i;
      if (cfg_we_i) men_q <= wdata_i[MEN_BIT];
    end
  end

  assign en_o  = en_q;
  assign men_o = men_q;
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] en_i,
  input  logic          men_i,
  output logic          pend_o,
  output logic          irq_o
);
  assign pend_o = |(stat_i & en_i);
  assign irq_o  = pend_o & men_i;
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int DW       = 32,
  parameter int TMR_BIT  = 19,
  parameter int PHY_BIT  = 26,
  parameter int MEN_BIT  = 8,
  parameter int PEND_BIT = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] evt_set_i,
  input  logic          tmr_evt_i,
  input  logic          phy_lvl_i,
  output logic          irq_o
);
  localparam logic [DW-1:0] SPECIAL_MASK = (DW'(1) << TMR_BIT) | (DW'(1) << PHY_BIT);

  logic [DW-1:0] stat_q, en_q, clr_vec, cfg_rd;
  logic          men_q, pend;
  reg_addr_e     addr;

  assign addr    = reg_addr_e'(addr_i);
  assign clr_vec = (wr_en_i && addr == ADDR_STAT) ? wdata_i : '0;

  irq_stat_bank #(.DW(DW), .TMR_BIT(TMR_BIT), .PHY_BIT(PHY_BIT)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_vec),
    .set_i     (evt_set_i & ~SPECIAL_MASK),
    .tmr_evt_i (tmr_evt_i),
    .tmr_en_i  (en_q[TMR_BIT]),
    .phy_lvl_i (phy_lvl_i),
    .stat_o    (stat_q)
  );

  irq_ctrl_regs #(.DW(DW), .MEN_BIT(MEN_BIT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_we_i  (wr_en_i && addr == ADDR_EN),
    .cfg_we_i (wr_en_i && addr == ADDR_CFG),
    .wdata_i  (wdata_i),
    .en_o     (en_q),
    .men_o    (men_q)
  );

  irq_level_gate #(.DW(DW)) u_gate (
    .stat_i (stat_q),
    .en_i   (en_q),
    .men_i  (men_q),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    cfg_rd           = '0;
    cfg_rd[PEND_BIT] = pend;
    cfg_rd[MEN_BIT]  = men_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr)
        ADDR_STAT: rdata_o = stat_q;
        ADDR_EN:   rdata_o = en_q;
        ADDR_CFG:  rdata_o = cfg_rd;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter int DW       = 32,
  parameter int TMR_BIT  = 19,
  parameter int PHY_BIT  = 26,
  parameter int MEN_BIT  = 8,
  parameter int PEND_BIT = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] evt_set_i,
  input logic          tmr_evt_i,
  input logic          phy_lvl_i,
  input logic          irq_o,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] en_q,
  input logic          men_q
);
  localparam logic [DW-1:0] GEN_MASK = ~((DW'(1) << TMR_BIT) | (DW'(1) << PHY_BIT));

  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && evt_set_i == '0 && !tmr_evt_i)
    |=> ((stat_q & $past(wdata_i) & GEN_MASK) == '0));

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_set_i & GEN_MASK) != '0)
    |=> ((stat_q & $past(evt_set_i) & GEN_MASK) == ($past(evt_set_i) & GEN_MASK)));

  p_tmr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_evt_i && en_q[TMR_BIT]) |=> stat_q[TMR_BIT]);

  p_tmr_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_q[TMR_BIT] && !(tmr_evt_i && en_q[TMR_BIT])) |=> !stat_q[TMR_BIT]);

  p_phy_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_lvl_i |=> stat_q[PHY_BIT]);

  p_pend_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd2) |-> (rdata_o[PEND_BIT] == ((stat_q & en_q) != '0)));

  p_gate_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !men_q |-> !irq_o);

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_q & en_q) != '0));

  p_cfg_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (men_q == $past(wdata_i[MEN_BIT])));

  p_en_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (en_q == $past(wdata_i)));
endmodule

bind irq_aggr irq_aggr_chk #(
  .DW(DW), .TMR_BIT(TMR_BIT), .PHY_BIT(PHY_BIT), .MEN_BIT(MEN_BIT), .PEND_BIT(PEND_BIT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .evt_set_i (evt_set_i),
  .tmr_evt_i (tmr_evt_i),
  .phy_lvl_i (phy_lvl_i),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .en_q      (en_q),
  .men_q     (men_q)
);

// File: tb/irq_aggr_bench.sv
module irq_aggr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int TMR  = 19;
  localparam int PHY  = 26;
  localparam int MEN  = 8;
  localparam int PEND = 12;
  localparam logic [DW-1:0] SPEC = (32'd1 << TMR) | (32'd1 << PHY);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, tmr_evt = 1'b0, phy_lvl = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0, evt_set = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] m_stat = '0, m_en = '0;
  logic          m_men = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggr u_irq_aggr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_set_i(evt_set),
    .tmr_evt_i(tmr_evt), .phy_lvl_i(phy_lvl), .irq_o(irq)
  );

  function automatic logic m_pend();
    return (m_stat & m_en) != '0;
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [1:0] a);
    logic [DW-1:0] c;
    c = '0;
    c[PEND] = m_pend();
    c[MEN]  = m_men;
    case (a)
      2'd0:    return m_stat;
      2'd1:    return m_en;
      2'd2:    return c;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [1:0] a, input logic [DW-1:0] d,
                      input logic [DW-1:0] s, input bit t, input bit p, input string req);
    logic [DW-1:0] nx;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt_set = s; tmr_evt = t; phy_lvl = p;
    @(posedge clk);
    nx = m_stat & ~((w && a == 2'd0) ? d : '0);
    nx = nx | (s & ~SPEC);
    if (t && m_en[TMR]) nx[TMR] = 1'b1;
    nx[PHY] = p;
    if (w && a == 2'd1) m_en = d;
    if (w && a == 2'd2) m_men = d[MEN];
    m_stat = nx;
    #(CLK_PERIOD/4);
    wr_en = 1'b0; evt_set = '0; tmr_evt = 1'b0;
    #1;
    chk(irq === (m_pend() & m_men), req, {31'd0, irq}, {31'd0, m_pend() & m_men});
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    chk(rdata === m_read(a), req, rdata, m_read(a));
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3);
    // R1 reset state
    chk(irq === 1'b0, "R1 irq", {31'd0, irq}, '0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset read");

    // R9 enable write / readback
    step(1, 2'd1, 32'hffff_ffff, '0, 0, 0, "R9");
    rd(2'd1, "R9 enable readback");
    // R6 pending visible with gate off; R7 pin low
    step(0, 2'd0, '0, 32'h0000_0011, 0, 0, "R7 gate off");
    rd(2'd2, "R6 pending flag gate off");
    chk(irq === 1'b0, "R7 pin gated", {31'd0, irq}, '0);
    // R8 cfg write only touches bit 8
    step(1, 2'd2, 32'hffff_ffff, '0, 0, 0, "R7 gate on");
    rd(2'd2, "R8 cfg readback");
    chk(irq === 1'b1, "R7 pin active", {31'd0, irq}, 32'd1);
    // R2 W1C partial
    step(1, 2'd0, 32'h0000_0001, '0, 0, 0, "R2");
    rd(2'd0, "R2 partial clear");
    // R3 set wins
    step(1, 2'd0, 32'h0000_0010, 32'h0000_0010, 0, 0, "R3");
    rd(2'd0, "R3 set beats clear");
    step(1, 2'd0, 32'hffff_ffff, '0, 0, 0, "R2 clear all");
    rd(2'd0, "R2 clear all");
    rd(2'd2, "R6 pending drops");
    // R4 timer gated off then on
    step(1, 2'd1, 32'h0000_00ff, '0, 0, 0, "R9");
    step(0, 2'd0, '0, '0, 1, 0, "R4 gated");
    rd(2'd0, "R4 timer ignored when disabled");
    step(1, 2'd1, 32'h0008_0000, '0, 0, 0, "R9");
    step(0, 2'd0, '0, '0, 1, 0, "R4 enabled");
    rd(2'd0, "R4 timer sets when enabled");
    // R5 phy level, clear cannot win
    step(1, 2'd1, 32'h0400_0000, '0, 0, 1, "R5");
    step(1, 2'd0, 32'h0400_0000, '0, 0, 1, "R5 clear attempt");
    rd(2'd0, "R5 phy held high");
    step(0, 2'd0, '0, '0, 0, 0, "R5 drop");
    rd(2'd0, "R5 phy follows low");
    // R10 special positions and reserved address
    step(1, 2'd0, 32'hffff_ffff, SPEC, 0, 0, "R10 special pulses");
    rd(2'd0, "R10 special pulses ignored");
    step(1, 2'd3, 32'hffff_ffff, '0, 0, 0, "R10 rsvd write");
    for (int a = 0; a < 4; a++) rd(2'(a), "R10 rsvd write no effect");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] s, d;
      s = $urandom & $urandom & $urandom;
      d = $urandom;
      step(($urandom % 3) != 0, 2'($urandom), d, s, ($urandom % 4) == 0,
           (($urandom % 8) == 0) ? ~phy_lvl : phy_lvl, "R7 random");
      if ((i % 4) == 0) rd(2'($urandom), "R2 R3 R6 random read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule